// File: doc/BRIEF.md
# Stepper Bridge Fault Diagnosis Encoder

This block turns the digital fault indications of a two-phase stepper power stage into a two-bit, active-low diagnosis code. Each bridge reports its on/off state, source-side and sink-side overcurrent flags, a strobe for every detected flyback pulse, a phase-reversal marker and a hold-current-range flag. One over-temperature pre-alarm is shared by both bridges. The block decides which of these count as faults, remembers them between readouts and hands a code to the serial readout logic.

Sink overcurrent counts only in a short window after a bridge turns on. After every turn-off the block expects a flyback strobe within a programmable number of cycles; if none arrives, that is a fault (open or shorted load). The check is skipped when the turn-off is a phase reversal made at hold current. Chopping commutations at hold current are still checked. A source overcurrent during an on-period cancels the flyback check for the turn-off that ends it.

Faults gather in sticky flags. A frame-start pulse loads the code of the gathered flags into the output register and clears the flags for the next period.

Top module: `stepdiag_top`

## Requirements
- R1: After reset `err_n` reads 2'b11. With no fault gathered, a readout also gives 2'b11. Bit 1 is the first error flag and bit 0 the second.
- R2: When several faults were gathered in one period, over-temperature (2'b00) wins over source overload (2'b10), and source overload wins over sink overload or missing flyback (2'b01).
- R3: A high `src_oc` on any bridge in any cycle gives code 2'b10 at the next readout.
- R4: `sink_oc` counts as a fault (code 2'b01) only in the cycle where `bridge_on` is first seen high and in the SINK_WIN-1 cycles after it, while `bridge_on` stays high. At other times it is ignored.
- R5: A turn-off is sampled in cycle t, the first cycle in which `bridge_on` is seen low after being high. A `fb_strobe` in cycles t+1 through t+`fb_window` clears the check. If no such strobe arrives, a missing-flyback fault (code 2'b01) is recorded at cycle t+`fb_window`.
- R6: A turn-off with `phase_rev` and `hold_rng` both high in cycle t gets no flyback check. A turn-off with only one of them high is still checked.
- R7: If `src_oc` was high during an on-period (from its first high cycle through cycle t), the turn-off that ends it gets no flyback check.
- R8: Faults are sticky. `err_n` changes only on the clock edge that samples `frame_start` high. On that edge it loads the code of the flags gathered before that edge and clears them. Faults present in the same cycle as `frame_start` go to the next period.
- R9: A high `ot_warn` in any cycle gives code 2'b00 at the next readout.
- R10: With `fb_window` at 0 the flyback check is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bridge_on | input | NB | Bridge driven (1) or off (0), one bit per bridge |
| src_oc | input | NB | Source-side overcurrent flag per bridge |
| sink_oc | input | NB | Sink-side overcurrent flag per bridge |
| fb_strobe | input | NB | Flyback pulse detected, per bridge |
| phase_rev | input | NB | Marks the current turn-off as a phase reversal |
| hold_rng | input | NB | Bridge is in the hold-current range |
| ot_warn | input | 1 | Over-temperature pre-alarm |
| fb_window | input | WIN_W | Flyback window length in cycles; 0 disables the check |
| frame_start | input | 1 | Readout strobe: capture the code and clear the flags |
| err_n | output | 2 | Active-low diagnosis code {error1, error2} |

## Verification
The bench places the last accepted flyback strobe on the final cycle of the window and the first rejected one just past it. A design off by one cycle in its window counter would report an open load for a valid pulse, or accept a late one. It also probes both edges of the sink turn-on window, so a design that is too wide or too narrow there flags, or misses, a sink overcurrent at those edges. Blanking is tried in all combinations of reversal and hold range, which exposes a design that blanks hold-range chopping or ignores the hold condition. Further checks cover:
- the mask left behind by a source overload, read across a readout boundary;
- a fault raised in the same cycle as a readout, which a design that drops the fault or reads it early would get wrong.

// File: rtl/stepdiag_pkg.sv
package stepdiag_pkg;

    // Gathered fault classes for one readout period
    typedef struct packed {
        logic ot;    // over-temperature pre-alarm
        logic src;   // source-side overload
        logic snk;   // sink overload right after turn-on
        logic nofb;  // flyback pulse absent
    } flags_t;

    // Active-low code, priority ot > src > (snk | nofb)
    function automatic logic [1:0] encode_flags(flags_t f);
        logic [1:0] c;
        if (f.ot)                c = 2'b00;
        else if (f.src)          c = 2'b10;
        else if (f.snk | f.nofb) c = 2'b01;
        else                     c = 2'b11;
        return c;
    endfunction

endpackage

// File: rtl/stepdiag_bridge.sv
module stepdiag_bridge #(
    parameter int WIN_W    = 8,
    parameter int SINK_WIN = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             on_i,
    input  logic             src_oc_i,
    input  logic             sink_oc_i,
    input  logic             fb_strobe_i,
    input  logic             phase_rev_i,
    input  logic             hold_i,
    input  logic [WIN_W-1:0] fb_window_i,
    output logic             src_ev_o,
    output logic             sink_ev_o,
    output logic             miss_ev_o
);

    localparam int SW_W = $clog2(SINK_WIN + 1);
    localparam logic [SW_W-1:0] SINK_LOAD = SW_W'(SINK_WIN - 1);

    typedef struct packed {
        logic             on_prev;
        logic             src_seen;
        logic             armed;
        logic [WIN_W-1:0] cnt;
        logic [SW_W-1:0]  sink_cnt;
    } bst_t;

    bst_t st_d, st_q;
    logic rise, fall, sink_open, masked, blank, miss;

    always_comb begin
        st_d      = st_q;
        rise      = on_i & ~st_q.on_prev;
        fall      = ~on_i & st_q.on_prev;
        sink_open = on_i & (rise | (st_q.sink_cnt != '0));
        masked    = st_q.src_seen | src_oc_i;
        blank     = phase_rev_i & hold_i;
        miss      = 1'b0;

        st_d.on_prev = on_i;

        // sink window after turn-on
        if (rise)                     st_d.sink_cnt = SINK_LOAD;
        else if (st_q.sink_cnt != '0) st_d.sink_cnt = st_q.sink_cnt - 1'b1;

        // source overload seen during this on-period
        if (rise)          st_d.src_seen = src_oc_i;
        else if (src_oc_i) st_d.src_seen = 1'b1;

        // flyback window countdown
        if (st_q.armed) begin
            if (fb_strobe_i) begin
                st_d.armed = 1'b0;
            end else if (st_q.cnt == WIN_W'(1)) begin
                miss       = 1'b1;
                st_d.armed = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end

        // a new turn-off restarts or cancels the check
        if (fall) begin
            if (!blank && !masked && (fb_window_i != '0)) begin
                st_d.armed = 1'b1;
                st_d.cnt   = fb_window_i;
            end else begin
                st_d.armed = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign src_ev_o  = src_oc_i;
    assign sink_ev_o = sink_oc_i & sink_open;
    assign miss_ev_o = miss;

    // R5: an unblanked, unmasked turn-off loads the window
    p_arm_on_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.on_prev && !on_i && !(phase_rev_i && hold_i) && !st_q.src_seen
         && !src_oc_i && fb_window_i != '0)
        |=> (st_q.armed && st_q.cnt == $past(fb_window_i)));

    // R6: reversal at hold current leaves no check running
    p_blank_rev_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.on_prev && !on_i && phase_rev_i && hold_i) |=> !st_q.armed);

    // R7: source overload in the on-period cancels the check
    p_src_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.on_prev && !on_i && src_oc_i) |=> !st_q.armed);

    // R10: zero window never arms
    p_zero_window_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.on_prev && !on_i && fb_window_i == '0) |=> !st_q.armed);

endmodule

// File: rtl/stepdiag_top.sv
module stepdiag_top
    import stepdiag_pkg::*;
#(
    parameter int NB       = 2,
    parameter int WIN_W    = 8,
    parameter int SINK_WIN = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NB-1:0]    bridge_on,
    input  logic [NB-1:0]    src_oc,
    input  logic [NB-1:0]    sink_oc,
    input  logic [NB-1:0]    fb_strobe,
    input  logic [NB-1:0]    phase_rev,
    input  logic [NB-1:0]    hold_rng,
    input  logic             ot_warn,
    input  logic [WIN_W-1:0] fb_window,
    input  logic             frame_start,
    output logic [1:0]       err_n
);

    typedef struct packed {
        flags_t     sticky;
        logic [1:0] code;
    } tst_t;

    logic [NB-1:0] src_ev, sink_ev, miss_ev;
    flags_t        ev;
    tst_t          st_d, st_q;

    for (genvar b = 0; b < NB; b++) begin : g_bridge
        stepdiag_bridge #(
            .WIN_W    (WIN_W),
            .SINK_WIN (SINK_WIN)
        ) u_bridge (
            .clk         (clk),
            .rst_n       (rst_n),
            .on_i        (bridge_on[b]),
            .src_oc_i    (src_oc[b]),
            .sink_oc_i   (sink_oc[b]),
            .fb_strobe_i (fb_strobe[b]),
            .phase_rev_i (phase_rev[b]),
            .hold_i      (hold_rng[b]),
            .fb_window_i (fb_window),
            .src_ev_o    (src_ev[b]),
            .sink_ev_o   (sink_ev[b]),
            .miss_ev_o   (miss_ev[b])
        );
    end

    always_comb begin
        ev.ot   = ot_warn;
        ev.src  = |src_ev;
        ev.snk  = |sink_ev;
        ev.nofb = |miss_ev;

        st_d = st_q;
        if (frame_start) begin
            st_d.code   = encode_flags(st_q.sticky);
            st_d.sticky = ev;
        end else begin
            st_d.sticky = st_q.sticky | ev;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sticky <= '0;
            st_q.code   <= 2'b11;
        end else begin
            st_q <= st_d;
        end
    end

    assign err_n = st_q.code;

    // R8: code only moves on a readout
    p_hold_between_reads_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(err_n));

    // R8: a readout with no new fault leaves the flags empty
    p_clear_on_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && !ot_warn && src_ev == '0 && sink_ev == '0 && miss_ev == '0)
        |=> st_q.sticky == '0);

    // R2: over-temperature wins whatever else was gathered
    p_ot_priority_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && st_q.sticky.ot) |=> err_n == 2'b00);

    // R1: the code is never left undefined
    p_code_known_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown(err_n));

endmodule

// File: tb/stepdiag_top_tb.sv
module stepdiag_top_tb;

    localparam int CLK_P = 10;
    localparam int NB    = 2;
    localparam int WIN_W = 8;

    // {ot, src, snk, nofb, expected code}
    localparam logic [5:0] VEC [8] = '{
        6'b0000_11, 6'b0001_01, 6'b0010_01, 6'b0100_10,
        6'b0101_10, 6'b0110_10, 6'b1000_00, 6'b1111_00
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NB-1:0]    bridge_on = '0, src_oc = '0, sink_oc = '0;
    logic [NB-1:0]    fb_strobe = '0, phase_rev = '0, hold_rng = '0;
    logic             ot_warn = 1'b0, frame_start = 1'b0;
    logic [WIN_W-1:0] fb_window = '0;
    logic [1:0]       err_n;
    logic [1:0]       rd;
    int               n_chk = 0, n_fail = 0;

    always #(CLK_P/2) clk = ~clk;

    stepdiag_top #(.NB(NB), .WIN_W(WIN_W), .SINK_WIN(4)) u_dut (
        .clk(clk), .rst_n(rst_n), .bridge_on(bridge_on), .src_oc(src_oc),
        .sink_oc(sink_oc), .fb_strobe(fb_strobe), .phase_rev(phase_rev),
        .hold_rng(hold_rng), .ot_warn(ot_warn), .fb_window(fb_window),
        .frame_start(frame_start), .err_n(err_n)
    );

    task automatic tick(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: err_n=%b expected %b", req, act, exp);
        end
    endtask

    task automatic read_code(output logic [1:0] c);
        frame_start = 1'b1;
        tick();
        frame_start = 1'b0;
        c = err_n;
    endtask

    // on-period of len cycles; returns at the negedge that drives the turn-off
    task automatic run_on(input int b, input int len, input bit src, input bit snk);
        bridge_on[b] = 1'b1;
        for (int i = 0; i < len; i++) begin
            src_oc[b]  = src && (i == 2);
            sink_oc[b] = snk && (i == 0);
            tick();
        end
        src_oc[b]    = 1'b0;
        sink_oc[b]   = 1'b0;
        bridge_on[b] = 1'b0;
    endtask

    task automatic sink_at(input int k, input logic [1:0] exp);
        fb_window = '0;
        read_code(rd);
        bridge_on[0] = 1'b1;
        for (int i = 0; i < 7; i++) begin
            sink_oc[0] = (i == k);
            tick();
        end
        sink_oc[0] = 1'b0;
        bridge_on[0] = 1'b0;
        tick(2);
        read_code(rd);
        chk($sformatf("R4 sink at cycle %0d", k), rd, exp);
    endtask

    task automatic strobe_at(input int k, input logic [1:0] exp);
        fb_window = 8'd4;
        read_code(rd);
        run_on(1, 5, 1'b0, 1'b0);
        tick(k);
        fb_strobe[1] = 1'b1;
        tick();
        fb_strobe[1] = 1'b0;
        tick(6);
        read_code(rd);
        chk($sformatf("R5 strobe at cycle %0d", k), rd, exp);
    endtask

    task automatic blank_case(input bit rev, input bit hold, input logic [1:0] exp);
        fb_window = 8'd4;
        read_code(rd);
        run_on(1, 5, 1'b0, 1'b0);
        phase_rev[1] = rev;
        hold_rng[1]  = hold;
        tick();
        phase_rev[1] = 1'b0;
        hold_rng[1]  = 1'b0;
        tick(6);
        read_code(rd);
        chk($sformatf("R6 rev=%0b hold=%0b", rev, hold), rd, exp);
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick();
        chk("R1 reset code", err_n, 2'b11);
        read_code(rd);
        chk("R1 idle readout", rd, 2'b11);

        // table walk: R2 priority, with R3, R4, R5, R9 single faults
        for (int v = 0; v < 8; v++) begin
            fb_window = VEC[v][2] ? 8'd4 : 8'd0;
            read_code(rd);
            run_on(0, 6, VEC[v][4], VEC[v][3]);
            ot_warn = VEC[v][5];
            tick();
            ot_warn = 1'b0;
            tick(6);
            read_code(rd);
            chk($sformatf("R2 vector %0d", v), rd, VEC[v][1:0]);
        end

        // R4 window edges (SINK_WIN = 4)
        sink_at(0, 2'b01);
        sink_at(3, 2'b01);
        sink_at(4, 2'b11);

        // R5 window edges (fb_window = 4)
        strobe_at(1, 2'b11);
        strobe_at(4, 2'b11);
        strobe_at(5, 2'b01);

        // R6 blanking only for reversal at hold current
        blank_case(1'b1, 1'b1, 2'b11);
        blank_case(1'b0, 1'b1, 2'b01);
        blank_case(1'b1, 1'b0, 2'b01);

        // R10 zero window: no flyback, no fault
        fb_window = '0;
        read_code(rd);
        run_on(1, 5, 1'b0, 1'b0);
        tick(8);
        read_code(rd);
        chk("R10 zero window", rd, 2'b11);

        // R7 source overload masks the later missing flyback
        fb_window = 8'd4;
        read_code(rd);
        run_on(0, 6, 1'b1, 1'b0);
        tick();
        read_code(rd);
        chk("R7 first read source", rd, 2'b10);
        tick(6);
        read_code(rd);
        chk("R7 masked flyback", rd, 2'b11);
        read_code(rd);
        run_on(0, 6, 1'b0, 1'b0);
        tick();
        read_code(rd);
        chk("R7 control first read", rd, 2'b11);
        tick(6);
        read_code(rd);
        chk("R7 control unmasked", rd, 2'b01);

        // R8 same-cycle fault goes to next period, code holds, flags clear
        read_code(rd);
        ot_warn = 1'b1;
        frame_start = 1'b1;
        tick();
        ot_warn = 1'b0;
        frame_start = 1'b0;
        chk("R8 same-cycle event excluded", err_n, 2'b11);
        read_code(rd);
        chk("R9 over-temperature", rd, 2'b00);
        src_oc[1] = 1'b1;
        tick();
        src_oc[1] = 1'b0;
        tick(3);
        chk("R8 code holds without readout", err_n, 2'b00);
        read_code(rd);
        chk("R3 source on bridge 1", rd, 2'b10);
        read_code(rd);
        chk("R8 flags cleared", rd, 2'b11);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_P * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule